// File: doc/BRIEF.md
# Period-Match Timer with Prescaler and Postscaler

This block is an 8-bit up-counter with a programmable period. It is driven from a slow tick, generated internally at one quarter of the system clock rate, and that tick passes through a selectable prescaler (divide by 1, 4 or 16). On each prescaled tick the counter is compared with the period register. When the two are equal, the counter returns to zero and the block emits a single-cycle match pulse. Otherwise the counter increments.

The unscaled match pulse is brought out directly so that a neighbouring block can use it as a PWM time base or a shift clock. The same pulse also drives a 4-bit postscaler. When the postscaler reaches its terminal count, it sets a sticky interrupt flag. An interrupt request output is high while both the flag and its enable are set.

Software reaches four byte-wide registers through a simple synchronous write port and a registered read port:

| Address | Contents |
|---------|----------|
| 0 | Counter |
| 1 | Period |
| 2 | Control |
| 3 | Interrupt: bit 0 flag, bit 1 enable |

Top module: `pmt_timer`

## Requirements
- R1: After synchronous reset the counter reads 0x00, the period reads 0xFF, the control reads 0x00, the flag and enable read 0, and `match_o` and `irq_o` are low.
- R2: With the timer on and prescale field 00, `match_o` pulses high for exactly one clock, once every (period+1)*4 clocks.
- R3: Prescale field (control bits 1:0) value 01 divides the tick by 4, and both 10 and 11 divide it by 16. Match spacing is then (period+1)*4*ratio clocks.
- R4: With postscale field value N (control bits 6:3), the flag is set on every (N+1)-th match pulse, counted from the last clear of the postscaler.
- R5: Control bit 2 is the timer-on bit. Control bit 7 is not stored and always reads 0. Bits 6:0 read back as written.
- R6: While the timer-on bit is 0, the counter holds its value and no match pulse occurs.
- R7: The flag is sticky. Writing address 3 with bit 0 = 0 clears it. If a postscaler terminal count and a clearing write occur on the same clock, the flag ends up set.
- R8: `irq_o` is high exactly when the flag and the enable (address 3 bit 1) are both 1.
- R9: A write to address 0 loads the counter. After a match the counter reads 0.
- R10: Any write to the counter or control register restarts the postscaler count, and the prescaler count, from zero.
- R11: With period 0 and prescale 1, a match pulse occurs on every tick (every 4 clocks) and the counter stays at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data for `bus_addr` |
| match_o | output | 1 | Unscaled single-cycle match pulse |
| irq_o | output | 1 | Interrupt request (flag AND enable) |

## Verification
The bench measures the distance between successive match pulses for several periods and all four prescale codes. A design that compared before incrementing, or that mapped code 11 to divide-by-1, would produce the wrong spacing.

A clearing write is timed to land on the exact clock of a postscaler terminal count. A design that let the clear win would lose that interrupt.

A control rewrite in the middle of a postscale interval must delay the flag by a full ratio. A design that kept the stale postscaler count would raise the flag one match early.

Period zero, the timer being switched off, and the unstored control bit 7 are each probed at the ports. Faults there show up as a missing pulse every tick, a drifting counter, or a 1 read back in bit 7.

// File: rtl/pmt_pkg.sv
package pmt_pkg;
  typedef enum logic [1:0] {
    REG_COUNT  = 2'd0,
    REG_PERIOD = 2'd1,
    REG_CTRL   = 2'd2,
    REG_IRQ    = 2'd3
  } pmt_reg_e;

  localparam int CTRL_ON_BIT  = 2;
  localparam int CTRL_PRE_LSB = 0;
  localparam int CTRL_PST_LSB = 3;
  localparam int IRQ_FLAG_BIT = 0;
  localparam int IRQ_EN_BIT   = 1;
endpackage

// File: rtl/pmt_tick.sv
module pmt_tick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (rst) phase_q <= '0;
    else if (phase_q == LAST) phase_q <= '0;
    else phase_q <= phase_q + 1'b1;
  end

  assign tick = (phase_q == LAST);
endmodule

// File: rtl/pmt_prescaler.sv
module pmt_prescaler #(
  parameter int PRE_W = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       tick_en,
  input  logic [1:0] sel,
  output logic       step
);
  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] limit;

  always_comb begin
    unique case (sel)
      2'b00:   limit = PRE_W'(0);
      2'b01:   limit = PRE_W'(3);
      default: limit = PRE_W'(15);
    endcase
  end

  assign step = tick_en && !clr && (cnt_q >= limit);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else if (tick_en) cnt_q <= (cnt_q >= limit) ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/pmt_counter.sv
module pmt_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] count,
  output logic             hit,
  output logic             match_q
);
  logic [CNT_W-1:0] cnt_q;

  assign hit   = step && !load && (cnt_q == period);
  assign count = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      match_q <= 1'b0;
    end else begin
      match_q <= hit;
      if (load) cnt_q <= load_val;
      else if (hit) cnt_q <= '0;
      else if (step) cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/pmt_postscaler.sv
module pmt_postscaler #(
  parameter int PST_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             hit,
  input  logic [PST_W-1:0] sel,
  output logic             term
);
  logic [PST_W-1:0] cnt_q;

  assign term = hit && !clr && (cnt_q >= sel);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else if (hit) cnt_q <= (cnt_q >= sel) ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/pmt_timer.sv
module pmt_timer
  import pmt_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int PST_W    = 4,
  parameter int PRE_W    = 4,
  parameter int TICK_DIV = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       bus_addr,
  input  logic             bus_wr,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  output logic             match_o,
  output logic             irq_o
);
  localparam int CTRL_W = CTRL_PST_LSB + PST_W;

  logic [CTRL_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  period_q;
  logic              flag_q, en_q;
  logic              flag_d, en_d;

  logic tick, step, hit, term;
  logic wr_cnt, wr_per, wr_ctl, wr_irq, clr_scale;
  logic [CNT_W-1:0] count;

  assign wr_cnt    = bus_wr && (bus_addr == REG_COUNT);
  assign wr_per    = bus_wr && (bus_addr == REG_PERIOD);
  assign wr_ctl    = bus_wr && (bus_addr == REG_CTRL);
  assign wr_irq    = bus_wr && (bus_addr == REG_IRQ);
  assign clr_scale = wr_cnt || wr_ctl;

  pmt_tick #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst(rst), .tick(tick)
  );

  pmt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .clr(clr_scale),
    .tick_en(tick && ctrl_q[CTRL_ON_BIT]),
    .sel(ctrl_q[CTRL_PRE_LSB +: 2]),
    .step(step)
  );

  pmt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .step(step), .load(wr_cnt),
    .load_val(bus_wdata[CNT_W-1:0]), .period(period_q),
    .count(count), .hit(hit), .match_q(match_o)
  );

  pmt_postscaler #(.PST_W(PST_W)) u_pst (
    .clk(clk), .rst(rst), .clr(clr_scale), .hit(hit),
    .sel(ctrl_q[CTRL_PST_LSB +: PST_W]), .term(term)
  );

  always_comb begin
    flag_d = flag_q;
    en_d   = en_q;
    if (wr_irq) begin
      flag_d = bus_wdata[IRQ_FLAG_BIT];
      en_d   = bus_wdata[IRQ_EN_BIT];
    end
    if (term) flag_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      period_q <= '1;
      flag_q   <= 1'b0;
      en_q     <= 1'b0;
      irq_o    <= 1'b0;
    end else begin
      if (wr_ctl) ctrl_q <= bus_wdata[CTRL_W-1:0];
      if (wr_per) period_q <= bus_wdata[CNT_W-1:0];
      flag_q <= flag_d;
      en_q   <= en_d;
      irq_o  <= flag_d && en_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else begin
      unique case (bus_addr)
        REG_COUNT:  bus_rdata <= 8'(count);
        REG_PERIOD: bus_rdata <= 8'(period_q);
        REG_CTRL:   bus_rdata <= 8'(ctrl_q);
        default:    bus_rdata <= {6'b0, en_q, flag_q};
      endcase
    end
  end
endmodule

// File: rtl/pmt_checker.sv
module pmt_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       bus_addr,
  input logic             bus_wr,
  input logic [7:0]       bus_wdata,
  input logic [7:0]       bus_rdata,
  input logic             match_o,
  input logic             irq_o,
  input logic             flag,
  input logic             enable,
  input logic             timer_on,
  input logic [CNT_W-1:0] count
);
  assert_match_single_R2: assert property (@(posedge clk) disable iff (rst)
    match_o |=> !match_o);

  assert_off_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    (!timer_on && !(bus_wr && bus_addr == 2'd0)) |=> (!match_o && $stable(count)));

  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (flag && !(bus_wr && bus_addr == 2'd3)) |=> flag);

  assert_flag_cause_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> (match_o || $past(bus_wr && bus_addr == 2'd3 && bus_wdata[0])));

  assert_irq_gate_R8: assert property (@(posedge clk) disable iff (rst)
    irq_o == (flag && enable));

  assert_bit7_zero_R5: assert property (@(posedge clk) disable iff (rst)
    $past(bus_addr == 2'd2) |-> !bus_rdata[7]);
endmodule

bind pmt_timer pmt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .match_o(match_o),
  .irq_o(irq_o), .flag(flag_q), .enable(en_q),
  .timer_on(ctrl_q[2]), .count(count)
);

// File: tb/sim_pmt_timer.sv
module sim_pmt_timer;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] bus_addr = 2'd0;
  logic bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic match_o, irq_o;

  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  int n_match = 0;

  always #10 clk = ~clk;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (match_o) n_match <= n_match + 1;
  end

  pmt_timer u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .match_o(match_o), .irq_o(irq_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    bus_addr = a;
    @(negedge clk);
    v = int'(bus_rdata);
  endtask

  task automatic wait_match(output int t);
    do @(negedge clk); while (!match_o);
    t = cyc;
  endtask

  task automatic gap_check(input string req, input int exp);
    int t0, t1;
    wait_match(t0);
    wait_match(t1);
    chk(t1 - t0 == exp, req, t1 - t0, exp);
  endtask

  task automatic t_reset;
    int v;
    rd(2'd0, v); chk(v == 0, "R1 count", v, 0);
    rd(2'd1, v); chk(v == 255, "R1 period", v, 255);
    rd(2'd2, v); chk(v == 0, "R1 ctrl", v, 0);
    rd(2'd3, v); chk(v == 0, "R1 irq reg", v, 0);
    chk(!match_o && !irq_o, "R1 outputs", int'({match_o, irq_o}), 0);
  endtask

  task automatic t_ctrl_layout;
    int v;
    wr(2'd2, 8'hFB);
    rd(2'd2, v); chk(v == 8'h7B, "R5 readback bit7 zero", v, 8'h7B);
    wr(2'd2, 8'h00);
  endtask

  task automatic t_off_hold;
    int v, m0;
    wr(2'd2, 8'h00);
    wr(2'd0, 8'h12);
    m0 = n_match;
    repeat (200) @(negedge clk);
    rd(2'd0, v); chk(v == 8'h12, "R6 R9 count held", v, 8'h12);
    chk(n_match == m0, "R6 no match when off", n_match - m0, 0);
  endtask

  task automatic t_basic;
    int t, v;
    wr(2'd1, 8'd9);
    wr(2'd2, 8'h04);
    gap_check("R2 period 9 div1", 40);
    @(negedge clk);
    chk(!match_o, "R2 pulse width", int'(match_o), 0);
    wr(2'd1, 8'd2);
    gap_check("R2 period 2 div1", 12);
    wait_match(t);
    rd(2'd0, v); chk(v == 0, "R9 count zero after match", v, 0);
  endtask

  task automatic t_prescale;
    wr(2'd1, 8'd3);
    wr(2'd2, 8'h05);
    gap_check("R3 code 01 div4", 64);
    wr(2'd1, 8'd1);
    wr(2'd2, 8'h06);
    gap_check("R3 code 10 div16", 128);
    wr(2'd2, 8'h07);
    gap_check("R3 code 11 div16", 128);
  endtask

  task automatic t_period_zero;
    int v;
    wr(2'd1, 8'd0);
    wr(2'd2, 8'h04);
    gap_check("R11 period 0 every tick", 4);
    rd(2'd0, v); chk(v == 0, "R11 count stays 0", v, 0);
  endtask

  task automatic t_postscale;
    int t;
    wr(2'd1, 8'd4);
    wr(2'd0, 8'd0);
    wr(2'd2, 8'h1C);
    wr(2'd3, 8'h02);
    for (int i = 1; i <= 4; i++) begin
      wait_match(t);
      chk(irq_o == (i == 4), "R4 R8 flag on 4th match", int'(irq_o), int'(i == 4));
    end
    wr(2'd3, 8'h00);
    @(negedge clk);
    chk(!irq_o, "R8 irq low when disabled", int'(irq_o), 0);
  endtask

  task automatic t_scaler_clear;
    int t, v;
    wr(2'd1, 8'd9);
    wr(2'd2, 8'h0C);
    wr(2'd3, 8'h00);
    wait_match(t);
    rd(2'd3, v); chk(v == 0, "R10 after first match", v, 0);
    wr(2'd2, 8'h0C);
    wait_match(t);
    rd(2'd3, v); chk(v == 0, "R10 ctrl write restarts postscaler", v, 0);
    wait_match(t);
    rd(2'd3, v); chk(v == 1, "R10 flag after full ratio", v, 1);
  endtask

  task automatic t_set_wins;
    int t, v;
    wr(2'd1, 8'd9);
    wr(2'd2, 8'h04);
    wr(2'd3, 8'h00);
    wait_match(t);
    repeat (39) @(negedge clk);
    wr(2'd3, 8'h00);
    chk(match_o, "R7 clear aligned with set event", int'(match_o), 1);
    rd(2'd3, v); chk(v == 1, "R7 set wins over clear", v, 1);
    repeat (5) @(negedge clk);
    rd(2'd3, v); chk(v == 1, "R7 flag sticky", v, 1);
    wr(2'd3, 8'h00);
    rd(2'd3, v); chk(v == 0, "R7 clear by write 0", v, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_ctrl_layout();
    t_off_hold();
    t_basic();
    t_prescale();
    t_period_zero();
    t_postscale();
    t_scaler_clear();
    t_set_wins();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule